// File: doc/BRIEF.md
# Fractional Clock Prescaler

This block divides the system clock by a programmable ratio of the form M + N/8 and emits a stream of single-cycle enable pulses for a downstream baud-rate generator. It produces no derived clock: every pulse is one system-clock cycle wide and lives in the system clock domain.

Software writes an 8-bit divisor word. Its top five bits give the integer part M and its bottom three bits give the eighths N. A 3-bit phase accumulator spreads the fraction over successive periods. Each period therefore lasts either M or M+1 cycles, and the long periods are spaced so that the average period equals the ratio exactly.

A newly written divisor is held aside and takes effect only at the next period boundary, so a change never yields a truncated period. After reset the ratio is 4.

Top module: `frac_prescaler`

## Requirements
- R1: After reset the ratio is 4. In the cycle in which reset is released, the pulse count is at its start. The first pulse is high in the fourth cycle of that count, and later pulses come every 4 cycles.
- R2: The divisor word encodes M in bits [7:3] and N in bits [2:0]. When N is 0, every period lasts exactly M cycles; this is checked for M = 5 and M = 31.
- R3: When N is not 0, every period lasts M or M+1 cycles. Across any 8 consecutive periods, exactly N periods are long, so the 8 periods total 8M+N cycles.
- R4: An integer part of 0 is treated as 1. Word 0x00 pulses in every cycle, and word 0x04 gives periods of 1 or 2 cycles averaging 1.5. The enable never stalls for longer than 32 cycles.
- R5: The output is a pulse one cycle wide: with a ratio of 2 or more, the cycle after a pulse has the output low. The output is never unknown after reset.
- R6: A write that does not fall on a pulse cycle leaves the period in progress at its old length. The new ratio governs the periods that follow the next pulse.
- R7: When several writes fall within one period, only the last one takes effect at the next boundary.
- R8: A write in the same cycle as a pulse takes effect immediately, governing the period that starts right after that pulse.
- R9: The largest ratio, word 0xFF (31.875), gives 8 consecutive periods totalling 255 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divReg | input | 8 | Divisor word: integer part in [7:3], eighths in [2:0] |
| divWrite | input | 1 | Write strobe for divReg, one cycle per write |
| tickOut | output | 1 | Single-cycle enable pulse |

## Verification
A divisor write and a period boundary can fall in the same cycle. In that cycle the block must choose between three sources for the next period: the word on the bus, a held pending word, or the active word.

The bench provokes this case by waiting for the cycle in which the pulse is visible and raising the write strobe in that same cycle. It then judges the result by the length of the very next period, which must already follow the new word, including the case of a ratio of 1, where the next pulse must follow at once. Separate directed cases place writes strictly inside a period, where the old length must survive.

// File: rtl/presc_pkg.sv
package presc_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic loadCfg;   // current period ends this cycle; start a new one
    logic takeNew;   // a fresh divisor word is offered for the next period
  } presc_strobe_t;

endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
#(
  parameter int INT_W = 5,
  parameter int FRAC_W = 3,
  parameter logic [INT_W+FRAC_W-1:0] RESET_DIV = 'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [INT_W+FRAC_W-1:0] divReg,
  input  logic                    divWrite,
  input  logic                    periodEnd,
  output presc_strobe_t           strobes,
  output logic [INT_W+FRAC_W-1:0] nextCfg
);

  localparam int DIV_W = INT_W + FRAC_W;

  logic [DIV_W-1:0] pendCfg;
  logic             pendValid;

  // A write on the bus wins over an older pending word at a boundary.
  always_comb begin
    strobes.loadCfg = periodEnd;
    strobes.takeNew = periodEnd && (divWrite || pendValid);
    nextCfg         = divWrite ? divReg : pendCfg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg   <= RESET_DIV;
      pendValid <= 1'b0;
    end else if (divWrite && !periodEnd) begin
      pendCfg   <= divReg;
      pendValid <= 1'b1;
    end else if (periodEnd) begin
      pendValid <= 1'b0;
    end
  end

endmodule

// File: rtl/presc_datapath.sv
module presc_datapath
  import presc_pkg::*;
#(
  parameter int INT_W = 5,
  parameter int FRAC_W = 3,
  parameter logic [INT_W+FRAC_W-1:0] RESET_DIV = 'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  presc_strobe_t           strobes,
  input  logic [INT_W+FRAC_W-1:0] nextCfg,
  output logic                    periodEnd
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam int CNT_W = INT_W;
  localparam logic [INT_W-1:0] RST_INT = RESET_DIV[DIV_W-1:FRAC_W];
  localparam logic [CNT_W-1:0] RST_CNT =
    (RST_INT == '0) ? '0 : CNT_W'(RST_INT - 1'b1);

  logic [DIV_W-1:0]  activeCfg;
  logic [DIV_W-1:0]  selCfg;
  logic [INT_W-1:0]  selInt;
  logic [FRAC_W-1:0] selFrac;
  logic [CNT_W-1:0]  effInt;
  logic [FRAC_W:0]   phaseSum;
  logic              carry;
  logic [CNT_W-1:0]  lenM1;
  logic [FRAC_W-1:0] phaseAcc;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    selCfg   = strobes.takeNew ? nextCfg : activeCfg;
    selInt   = selCfg[DIV_W-1:FRAC_W];
    selFrac  = selCfg[FRAC_W-1:0];
    effInt   = (selInt == '0) ? CNT_W'(1) : CNT_W'(selInt);
    phaseSum = {1'b0, phaseAcc} + {1'b0, selFrac};
    carry    = phaseSum[FRAC_W];
    lenM1    = effInt - CNT_W'(1) + {{(CNT_W-1){1'b0}}, carry};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCfg <= RESET_DIV;
      phaseAcc  <= '0;
      cnt       <= RST_CNT;
    end else if (strobes.loadCfg) begin
      cnt      <= lenM1;
      phaseAcc <= phaseSum[FRAC_W-1:0];
      if (strobes.takeNew) activeCfg <= nextCfg;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign periodEnd = (cnt == '0);

endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler
  import presc_pkg::*;
#(
  parameter int INT_W = 5,
  parameter int FRAC_W = 3,
  parameter logic [INT_W+FRAC_W-1:0] RESET_DIV = 'h20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [INT_W+FRAC_W-1:0] divReg,
  input  logic                    divWrite,
  output logic                    tickOut
);

  localparam int DIV_W = INT_W + FRAC_W;

  presc_strobe_t    strobes;
  logic [DIV_W-1:0] nextCfg;
  logic             periodEnd;

  presc_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RESET_DIV(RESET_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .divReg(divReg), .divWrite(divWrite),
    .periodEnd(periodEnd), .strobes(strobes), .nextCfg(nextCfg)
  );

  presc_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RESET_DIV(RESET_DIV)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nextCfg(nextCfg),
    .periodEnd(periodEnd)
  );

  assign tickOut = periodEnd;

endmodule

// File: rtl/frac_prescaler_chk.sv
module frac_prescaler_chk #(
  parameter int INT_W = 5,
  parameter int FRAC_W = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [INT_W+FRAC_W-1:0] divReg,
  input logic                    divWrite,
  input logic                    tickOut
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam int MAX_LEN = 1 << INT_W;

  logic [INT_W:0] gap;
  logic [2:0]     sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap      <= '0;
      sinceRst <= '0;
    end else begin
      gap <= tickOut ? '0 : ((gap == '1) ? gap : gap + 1'b1);
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
    end
  end

  // R1
  reset_ratio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd3) |-> !tickOut);

  // R4
  no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    gap < (INT_W+1)'(MAX_LEN));

  // R5
  known_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(tickOut));

  // R8
  boundary_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divWrite && tickOut && divReg[DIV_W-1:FRAC_W] <= 1 &&
     divReg[FRAC_W-1:0] == '0) |=> tickOut);

endmodule

bind frac_prescaler frac_prescaler_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uChk (
  .clk(clk), .rstN(rstN), .divReg(divReg), .divWrite(divWrite), .tickOut(tickOut)
);

// File: tb/sim_frac_prescaler.sv
module sim_frac_prescaler;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divReg = 8'h00;
  logic       divWrite = 1'b0;
  logic       tickOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  frac_prescaler u0 (
    .clk(clk), .rstN(rstN), .divReg(divReg), .divWrite(divWrite), .tickOut(tickOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    divReg = v;
    divWrite = 1'b1;
    @(negedge clk);
    divWrite = 1'b0;
  endtask

  task automatic waitTick();
    while (!tickOut) @(negedge clk);
  endtask

  task automatic measureOne(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!tickOut);
  endtask

  task automatic testReset();
    int c = 0;
    int len;
    check(tickOut == 1'b0, "R1 output low at reset release", int'(tickOut), 0);
    while (!tickOut) begin
      @(negedge clk);
      c++;
    end
    check(c == 3, "R1 first pulse position", c, 3);
    for (int i = 0; i < 3; i++) begin
      measureOne(len);
      check(len == 4, "R1 reset ratio 4", len, 4);
    end
  endtask

  task automatic testInteger(input logic [7:0] v, input int m);
    int len;
    writeReg(v);
    waitTick();
    @(negedge clk);
    check(tickOut == 1'b0, "R5 single-cycle pulse", int'(tickOut), 0);
    waitTick();
    for (int i = 0; i < 3; i++) begin
      measureOne(len);
      check(len == m, "R2 integer period", len, m);
    end
  endtask

  task automatic testFraction(input logic [7:0] v, input string tag);
    int m = int'(v[7:3]);
    int n = int'(v[2:0]);
    int meff;
    int len;
    int total = 0;
    int longs = 0;
    meff = (m == 0) ? 1 : m;
    writeReg(v);
    waitTick();
    for (int i = 0; i < 8; i++) begin
      measureOne(len);
      total += len;
      if (len == meff + 1) longs++;
      check(len == meff || len == meff + 1, {tag, " period in range"}, len, meff);
    end
    check(longs == n, {tag, " long period count"}, longs, n);
    check(total == 8 * meff + n, {tag, " eight-period total"}, total, 8 * meff + n);
  endtask

  task automatic testZero();
    int len;
    writeReg(8'h00);
    waitTick();
    for (int i = 0; i < 4; i++) begin
      measureOne(len);
      check(len == 1, "R4 zero integer acts as 1", len, 1);
    end
  endtask

  task automatic testMidWrite();
    int c = 0;
    int len;
    writeReg(8'hA0);
    waitTick();
    do begin
      @(negedge clk);
      c++;
      if (c == 5) begin
        divReg = 8'h10;
        divWrite = 1'b1;
      end else divWrite = 1'b0;
    end while (!tickOut);
    divWrite = 1'b0;
    check(c == 20, "R6 period in progress keeps old length", c, 20);
    measureOne(len);
    check(len == 2, "R6 new ratio after boundary", len, 2);
  endtask

  task automatic testLastWins();
    int c = 0;
    int len;
    writeReg(8'hA0);
    waitTick();
    do begin
      @(negedge clk);
      c++;
      if (c == 3) begin
        divReg = 8'h18;
        divWrite = 1'b1;
      end else if (c == 6) begin
        divReg = 8'h30;
        divWrite = 1'b1;
      end else divWrite = 1'b0;
    end while (!tickOut);
    divWrite = 1'b0;
    check(c == 20, "R7 old length kept", c, 20);
    for (int i = 0; i < 2; i++) begin
      measureOne(len);
      check(len == 6, "R7 last write wins", len, 6);
    end
  endtask

  task automatic testBoundary();
    int len;
    writeReg(8'hA0);
    waitTick();
    divReg = 8'h18;
    divWrite = 1'b1;
    measureOne(len);
    divWrite = 1'b0;
    check(len == 3, "R8 write on pulse applies at once", len, 3);
    divReg = 8'h08;
    divWrite = 1'b1;
    @(negedge clk);
    divWrite = 1'b0;
    check(tickOut == 1'b1, "R8 ratio 1 on pulse cycle", int'(tickOut), 1);
    measureOne(len);
    check(len == 1, "R8 ratio 1 sustained", len, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testInteger(8'h28, 5);
    testInteger(8'hF8, 31);
    testFraction(8'h23, "R3 ratio 4.375");
    testFraction(8'h0F, "R3 ratio 1.875");
    testFraction(8'h04, "R4 ratio 0.5 as 1.5");
    testFraction(8'hFF, "R9 ratio 31.875");
    testZero();
    testMidWrite();
    testLastWins();
    testBoundary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule